// File: doc/BRIEF.md
# Three-Wire Serial Command Engine

This block is the slave side of a three-wire serial link. The wires are a chip-enable, a serial clock, and one data line that both the host and the slave drive. A fast system clock oversamples all three pins. Each frame opens with an 8-bit command byte, sent least significant bit first, which sets the direction, the target space (clock registers or RAM) and the address. After the command the engine either collects write bytes or returns read bytes. It drives a simple single-cycle access port toward the storage, which lives outside this block.

The host changes input data while the serial clock is low, and the engine samples it on the rising edge. Read data goes out after each falling edge. The engine releases the line again on each rising edge, so the host can turn the line around without contention. Address 31 in either space selects a burst. A burst starts at address 0 and steps upward until chip-enable drops. The pad itself is outside the block: the engine supplies output data and an output enable, and the pad performs the tri-state.

Top module: `tw_serial_slave`

## Requirements
- R1: After reset, and within three system clocks of chip-enable going low, `sdata_oe` is 0, and no access pulse is issued while chip-enable stays low.
- R2: The command byte is received least significant bit first. Bit 0 is the direction (0 write, 1 read), bits 5:1 are the address, bit 6 is the space (0 clock, 1 RAM) and is presented on `acc_ram`, and bit 7 enables writes.
- R3: A single write (address 0..30, bit 7 set) takes the next 8 bits, LSB first, as one byte. It issues exactly one `acc_wr` at the command address. Further serial clocks in the frame cause no access.
- R4: A write command with bit 7 clear issues no `acc_wr` for any data that follows.
- R5: A read command issues `acc_rd` for its address once the eighth command bit has been sampled. Bit 0 of the returned byte is driven after the next falling edge, and the following bits go out LSB first, one per falling edge.
- R6: Every rising serial clock edge during a read releases the data line (`sdata_oe` low) until the next falling edge.
- R7: A single read keeps sending the same byte again for every further 8 clocks, with no further `acc_rd`.
- R8: A burst write (address 31) writes each completed byte to consecutive addresses starting at 0. The address wraps from 30 back to 0.
- R9: A burst read returns the bytes at addresses 0, 1, 2, ... in order. It fetches the next address after the eighth bit of each byte goes out, so reading n bytes costs n+1 `acc_rd` pulses.
- R10: Chip-enable going low ends the frame. A partly received byte is never written, and the next frame decodes normally.
- R11: If the serial clock is high when chip-enable rises, the whole frame is ignored: no access and no drive.
- R12: `acc_wr` and `acc_rd` are single-cycle pulses and are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Serial chip-enable; high frames a transfer |
| sclk | input | 1 | Serial clock |
| sdata_in | input | 1 | Data line as seen at the pad input |
| sdata_out | output | 1 | Value to drive onto the data line |
| sdata_oe | output | 1 | Pad output enable for the data line |
| acc_wr | output | 1 | Write strobe to storage, one cycle |
| acc_rd | output | 1 | Read strobe to storage, one cycle |
| acc_ram | output | 1 | Space select: 0 clock registers, 1 RAM |
| acc_addr | output | 5 | Storage address |
| acc_wdata | output | 8 | Write data, valid with `acc_wr` |
| acc_rdata | input | 8 | Read data, valid in the cycle `acc_rd` is high |

## Verification
Some properties hold on every cycle, and the assertions check them there: the line is released after a rising edge and whenever chip-enable is low, the output enable turns on only right after a falling edge, and the access strobes are exclusive single pulses. Other behaviour can only be shown by a sequence of scenarios in the bench: the bit order and field decoding of the command, the ignored trailing clocks of a single write, the retransmission of a single read, burst address stepping with wrap, abort mid-byte, and rejection of a frame that begins with the serial clock high.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 5;
  localparam int CNT_W   = $clog2(DATA_W);
  localparam logic [ADDR_W-1:0] ADDR_BURST = '1;
  localparam logic [ADDR_W-1:0] ADDR_LAST  = ADDR_BURST - 1'b1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_WDATA, ST_RDATA, ST_SKIP
  } tw_state_e;

  // command byte fields, msb first
  typedef struct packed {
    logic              wr_en;
    logic              ram;
    logic [ADDR_W-1:0] addr;
    logic              rd;
  } tw_cmd_t;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/tw_edge.sv
module tw_edge #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;
endmodule

// File: rtl/tw_frame.sv
module tw_frame
  import tw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_s,
  input  logic              ce_rise,
  input  logic              sclk_s,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              din_s,
  input  logic [DATA_W-1:0] acc_rdata,
  output logic              acc_wr,
  output logic              acc_rd,
  output logic              acc_ram,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] acc_wdata,
  output logic              sd_out,
  output logic              sd_oe
);
  tw_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d, rbuf_q, rbuf_d, wdata_q, wdata_d;
  tw_cmd_t           cmd_q, cmd_d, cmd_in;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              burst_q, burst_d;
  logic              wr_q, wr_d, rd_q, rd_d, oe_q, oe_d, out_q, out_d;
  logic [DATA_W-1:0] shifted;
  logic              last_bit;

  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return (a == ADDR_LAST) ? '0 : a + 1'b1;
  endfunction

  assign shifted  = {din_s, sh_q[DATA_W-1:1]};
  assign cmd_in   = tw_cmd_t'(shifted);
  assign last_bit = (cnt_q == CNT_W'(DATA_W - 1));

  always_comb begin
    state_d = state_q;  cnt_d   = cnt_q;   sh_d    = sh_q;
    cmd_d   = cmd_q;    addr_d  = addr_q;  burst_d = burst_q;
    rbuf_d  = rbuf_q;   wdata_d = wdata_q; out_d   = out_q;
    oe_d    = 1'b0;     wr_d    = 1'b0;    rd_d    = 1'b0;
    if (rd_q) rbuf_d = acc_rdata;
    if (wr_q && burst_q) addr_d = addr_step(addr_q);
    if (!ce_s) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (ce_rise) begin
            state_d = sclk_s ? ST_SKIP : ST_CMD;
            cnt_d   = '0;
          end
        end
        ST_CMD: begin
          if (sclk_rise) begin
            sh_d  = shifted;
            cnt_d = cnt_q + 1'b1;
            if (last_bit) begin
              cmd_d   = cmd_in;
              burst_d = (cmd_in.addr == ADDR_BURST);
              addr_d  = (cmd_in.addr == ADDR_BURST) ? '0 : cmd_in.addr;
              if (cmd_in.rd) begin
                rd_d    = 1'b1;
                state_d = ST_RDATA;
              end else begin
                state_d = cmd_in.wr_en ? ST_WDATA : ST_SKIP;
              end
            end
          end
        end
        ST_WDATA: begin
          if (sclk_rise) begin
            sh_d  = shifted;
            cnt_d = cnt_q + 1'b1;
            if (last_bit) begin
              wr_d    = 1'b1;
              wdata_d = shifted;
              if (!burst_q) state_d = ST_SKIP;
            end
          end
        end
        ST_RDATA: begin
          oe_d = oe_q;
          if (sclk_rise) begin
            oe_d = 1'b0;
          end else if (sclk_fall) begin
            oe_d  = 1'b1;
            out_d = rbuf_q[cnt_q];
            cnt_d = cnt_q + 1'b1;
            if (last_bit && burst_q) begin
              addr_d = addr_step(addr_q);
              rd_d   = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; cnt_q   <= '0;   sh_q    <= '0;
      cmd_q   <= '0;      addr_q  <= '0;   burst_q <= 1'b0;
      rbuf_q  <= '0;      wdata_q <= '0;   out_q   <= 1'b0;
      oe_q    <= 1'b0;    wr_q    <= 1'b0; rd_q    <= 1'b0;
    end else begin
      state_q <= state_d; cnt_q   <= cnt_d;   sh_q    <= sh_d;
      cmd_q   <= cmd_d;   addr_q  <= addr_d;  burst_q <= burst_d;
      rbuf_q  <= rbuf_d;  wdata_q <= wdata_d; out_q   <= out_d;
      oe_q    <= oe_d;    wr_q    <= wr_d;    rd_q    <= rd_d;
    end
  end

  assign acc_wr    = wr_q;
  assign acc_rd    = rd_q;
  assign acc_ram   = cmd_q.ram;
  assign acc_addr  = addr_q;
  assign acc_wdata = wdata_q;
  assign sd_out    = out_q;
  assign sd_oe     = oe_q;
endmodule

// File: rtl/tw_serial_slave.sv
module tw_serial_slave
  import tw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              sclk,
  input  logic              sdata_in,
  output logic              sdata_out,
  output logic              sdata_oe,
  output logic              acc_wr,
  output logic              acc_rd,
  output logic              acc_ram,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] acc_wdata,
  input  logic [DATA_W-1:0] acc_rdata
);
  logic ce_s, sclk_s, din_s;
  logic ce_rise, sclk_rise, sclk_fall, ce_fall_unused;

  tw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sdata_in, sclk, ce}),
    .q({din_s, sclk_s, ce_s})
  );

  tw_edge #(.WIDTH(2)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .level({sclk_s, ce_s}),
    .rise({sclk_rise, ce_rise}),
    .fall({sclk_fall, ce_fall_unused})
  );

  tw_frame u_frame (
    .clk(clk), .rst_n(rst_n),
    .ce_s(ce_s), .ce_rise(ce_rise),
    .sclk_s(sclk_s), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .din_s(din_s), .acc_rdata(acc_rdata),
    .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_ram(acc_ram),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .sd_out(sdata_out), .sd_oe(sdata_oe)
  );
endmodule

// File: rtl/tw_serial_slave_chk.sv
module tw_serial_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_s,
  input logic sclk_rise,
  input logic sclk_fall,
  input logic sdata_oe,
  input logic acc_wr,
  input logic acc_rd
);
  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> !sdata_oe);

  // R6
  rise_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> !sdata_oe);

  // R5
  drive_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdata_oe) |-> $past(sclk_fall));

  // R12
  access_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_wr && acc_rd));

  // R12
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> !acc_wr);

  // R12
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> !acc_rd);

  // R1
  idle_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_s && $past(!ce_s)) |-> !(acc_wr || acc_rd));
endmodule

bind tw_serial_slave tw_serial_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_s(ce_s),
  .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
  .sdata_oe(sdata_oe), .acc_wr(acc_wr), .acc_rd(acc_rd)
);

// File: tb/tw_serial_slave_bench.sv
`timescale 1ns/1ps
module tw_serial_slave_bench;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0, sclk = 1'b0, sdata_in = 1'b0;
  logic sdata_out, sdata_oe, acc_wr, acc_rd, acc_ram;
  logic [4:0] acc_addr;
  logic [7:0] acc_wdata, acc_rdata;

  int n_chk = 0, n_bad = 0, wr_n = 0, rd_n = 0, both_n = 0;
  logic [4:0] lw_addr [64];
  logic [7:0] lw_data [64];
  logic       lw_ram  [64];
  logic [7:0] wdat    [64];
  bit done = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] mem_f(input logic sp, input logic [4:0] a);
    return ({a, 3'b0} ^ (sp ? 8'hA5 : 8'h3C)) + {3'b0, a};
  endfunction

  assign acc_rdata = mem_f(acc_ram, acc_addr);

  tw_serial_slave u_tw_serial_slave (
    .clk(clk), .rst_n(rst_n), .ce(ce), .sclk(sclk), .sdata_in(sdata_in),
    .sdata_out(sdata_out), .sdata_oe(sdata_oe), .acc_wr(acc_wr), .acc_rd(acc_rd),
    .acc_ram(acc_ram), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata)
  );

  always @(negedge clk) begin
    if (acc_wr) begin
      if (wr_n < 64) begin
        lw_addr[wr_n] = acc_addr; lw_data[wr_n] = acc_wdata; lw_ram[wr_n] = acc_ram;
      end
      wr_n = wr_n + 1;
    end
    if (acc_rd) rd_n = rd_n + 1;
    if (acc_wr && acc_rd) both_n = both_n + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdata_in = b; wait_clk(HALF);
    sclk = 1'b1;  wait_clk(HALF);
    sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic recv_byte(output logic [7:0] v, inout int bad_oe);
    for (int i = 0; i < 8; i++) begin
      wait_clk(HALF);
      if (!sdata_oe) bad_oe++;
      v[i] = sdata_out;
      sclk = 1'b1; wait_clk(HALF);
      if (sdata_oe) bad_oe++;
      sclk = 1'b0;
    end
  endtask

  task automatic frame(input logic sp, input logic [4:0] a, input logic rd,
                       input logic we, input int n, input bit sclk_hi, input int cut_bits);
    logic [7:0] cmd, got, exp;
    int bad_oe, exp_w;
    bit burst;
    string req;
    cmd = {we, sp, a, rd};
    burst = (a == 5'd31);
    for (int i = 0; i < n; i++) wdat[i] = 8'($urandom);
    wr_n = 0; rd_n = 0; bad_oe = 0;
    sclk = sclk_hi; wait_clk(4);
    ce = 1'b1; wait_clk(HALF);
    sclk = 1'b0; wait_clk(HALF);
    send_byte(cmd);
    if (rd && !sclk_hi) begin
      for (int i = 0; i < n; i++) begin
        recv_byte(got, bad_oe);
        exp = mem_f(sp, burst ? 5'(i % 31) : a);
        req = (i == 0) ? "R5" : (burst ? "R9" : "R7");
        chk(got == exp, req, "read byte", int'(got), int'(exp));
      end
      chk(bad_oe == 0, "R6", "drive/release errors", bad_oe, 0);
      chk(rd_n == (burst ? n + 1 : 1), burst ? "R9" : "R7", "read strobes",
          rd_n, burst ? n + 1 : 1);
    end else begin
      for (int i = 0; i < n; i++) send_byte(wdat[i]);
      for (int i = 0; i < cut_bits; i++) send_bit(1'b1);
    end
    wait_clk(4);
    ce = 1'b0; wait_clk(6);
    chk(!sdata_oe, "R1", "oe after ce low", int'(sdata_oe), 0);
    if (!rd || sclk_hi) begin
      exp_w = (sclk_hi || !we) ? 0 : (burst ? n : 1);
      req = sclk_hi ? "R11" : (!we ? "R4" : (cut_bits > 0 ? "R10" : (burst ? "R8" : "R3")));
      chk(wr_n == exp_w, req, "write count", wr_n, exp_w);
      if (sclk_hi) chk(rd_n == 0, "R11", "read strobes", rd_n, 0);
      for (int k = 0; k < exp_w && k < wr_n && k < 64; k++) begin
        chk(lw_addr[k] == (burst ? 5'(k % 31) : a), burst ? "R8" : "R3", "write addr",
            int'(lw_addr[k]), burst ? k % 31 : int'(a));
        chk(lw_data[k] == wdat[k], "R2", "write data", int'(lw_data[k]), int'(wdat[k]));
        chk(lw_ram[k] == sp, "R2", "space bit", int'(lw_ram[k]), int'(sp));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    wait_clk(5);
    chk(!sdata_oe && !acc_wr && !acc_rd, "R1", "outputs in reset",
        int'({sdata_oe, acc_wr, acc_rd}), 0);
    rst_n = 1'b1;
    wait_clk(5);
    chk(!sdata_oe && !acc_wr && !acc_rd, "R1", "outputs after reset",
        int'({sdata_oe, acc_wr, acc_rd}), 0);
    frame(1'b0, 5'd5,  1'b0, 1'b1, 3,  1'b0, 0);  // R3 trailing clocks ignored
    frame(1'b1, 5'd9,  1'b0, 1'b0, 2,  1'b0, 0);  // R4 write disabled
    frame(1'b1, 5'd7,  1'b1, 1'b1, 3,  1'b0, 0);  // R5 R7 single read repeats
    frame(1'b0, 5'd31, 1'b0, 1'b1, 33, 1'b0, 0);  // R8 burst write wraps
    frame(1'b1, 5'd31, 1'b1, 1'b1, 3,  1'b0, 0);  // R9 burst read
    frame(1'b0, 5'd31, 1'b0, 1'b1, 1,  1'b0, 4);  // R10 abort mid byte
    frame(1'b1, 5'd3,  1'b0, 1'b1, 1,  1'b1, 0);  // R11 sclk high at start
    frame(1'b1, 5'd3,  1'b0, 1'b1, 1,  1'b0, 0);  // R10 next frame decodes
    for (int f = 0; f < 40; f++) begin
      logic [4:0] a;
      a = ($urandom % 4 == 0) ? 5'd31 : 5'($urandom % 31);
      frame(1'($urandom), a, 1'($urandom), ($urandom % 5) != 0,
            1 + int'($urandom % 4), 1'b0, 0);
    end
    chk(both_n == 0, "R12", "overlapping strobes", both_n, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule